// File: doc/BRIEF.md
# Gated Phase-Frequency Detector with Lock Indicator

This block compares two divided pulse streams, one derived from the reference oscillator and one from the VCO, and turns their phase difference into pump commands. A rising edge on the reference stream arms the "up" command. A rising edge on the VCO stream arms the "down" command. Once both are armed, both are cleared together after a short, parameterised delay. A three-state enable is high whenever either command is active. A polarity input, high for normal sense, can exchange the two commands at the outputs. The VCO-side command is an open-drain style output, so a high level means "pull low" and a low level means "released".

A lock flag stays high while the loop is aligned. It drops for as long as any pump pulse has been held for longer than a threshold number of clocks, so a locked loop shows only short low glitches. A power-down request, active low, is deferred until both commands are idle, which avoids cutting a pump pulse short and jumping the frequency. While the block is asleep, the commands are forced inactive, the lock flag is low and new edges are ignored. The analog pump current and the loop filter are outside this block. There is no data stream here, so every pin is a plain control or status level with no valid/ready handshake and no back-pressure. Every input is sampled on the rising edge of the single clock.

Top module: `pfd_lock_gate`

## Requirements
- R1: After reset, pump_up, pump_dn_pull, pump_en and asleep are 0 and lock_ok is 1.
- R2: A 0-to-1 change on ref_div arms the up command at the next clock edge. The command then stays armed while ref_div remains high and the VCO side is not armed.
- R3: A 0-to-1 change on vco_div arms the down command at the next clock edge.
- R4: Once both commands are armed, both stay armed for exactly CLR_DLY cycles and then both clear together.
- R5: With pol_norm=1, pump_up carries the up command and pump_dn_pull carries the down command. With pol_norm=0, the two are exchanged.
- R6: pump_en is 1 exactly when at least one command is armed.
- R7: lock_ok is 0 in every cycle where a pump pulse (either command armed) has already lasted LOCK_THR cycles or more, and lock_ok is 1 otherwise.
- R8: With pd_req_n=0, asleep stays 0 while any command is armed, and asleep becomes 1 at the clock edge after a cycle in which both commands are idle.
- R9: While asleep=1, every command output is 0, lock_ok is 0 and edges are ignored. Raising pd_req_n clears asleep at the next edge, after which the next input edge arms its command again.
- R10: ref_mon equals ref_div as sampled at the previous clock edge.
- R11: An input edge that arrives in the same cycle as the joint clear is dropped, and the command stays cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_div | input | 1 | Divided reference pulse stream |
| vco_div | input | 1 | Divided VCO pulse stream |
| pol_norm | input | 1 | 1 = normal polarity, 0 = up/down exchanged |
| pd_req_n | input | 1 | Power-down request, active low |
| pump_up | output | 1 | Reference-side pump command, driven level |
| pump_dn_pull | output | 1 | VCO-side pump command, 1 = pull low, 0 = released |
| pump_en | output | 1 | Pump enable, 0 = high-impedance idle |
| lock_ok | output | 1 | Lock flag, high while aligned |
| ref_mon | output | 1 | Monitor of the sampled reference input |
| asleep | output | 1 | 1 while powered down |

## Verification
The bench builds the block with CLR_DLY=2 and LOCK_THR=4. A two-cycle clear window means a reference edge can be placed inside the clear cycle, which exercises the dropped-edge case. A threshold of four means lock loss and recovery both occur within a few cycles of a leading edge. With these values, the deferred power-down request has a multi-cycle pump pulse to wait for. Polarity swaps and power-down windows also land on pulses of every width that the sliding phase offsets produce.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  typedef enum logic [1:0] {
    PW_RUN   = 2'd0,
    PW_DRAIN = 2'd1,
    PW_SLEEP = 2'd2
  } pwr_state_e;
endpackage

// File: rtl/pfd_side.sv
module pfd_side (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_in,
  input  logic hold,
  input  logic clr,
  output logic armed
);
  logic seen;
  logic rise;

  assign rise = pulse_in & ~seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen  <= 1'b0;
      armed <= 1'b0;
    end else begin
      seen <= pulse_in;
      if (hold || clr) armed <= 1'b0;
      else if (rise)   armed <= 1'b1;
    end
  end

  // a command only comes up after an input edge
  assert_rise_needs_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(pulse_in && !seen));
endmodule

// File: rtl/pfd_lock_mon.sv
module pfd_lock_mon #(
  parameter int LOCK_THR = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic sleep,
  output logic lock_ok
);
  localparam int WW = $clog2(LOCK_THR + 1);
  localparam logic [WW-1:0] THR_V = WW'(LOCK_THR);

  logic [WW-1:0] wid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          wid <= '0;
    else if (!busy)      wid <= '0;
    else if (wid != THR_V) wid <= wid + 1'b1;
  end

  assign lock_ok = !sleep && !(busy && (wid == THR_V));

  // the first cycle of a fresh pulse never drops lock
  assert_fresh_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> lock_ok);
endmodule

// File: rtl/pfd_pwr_ctl.sv
module pfd_pwr_ctl
  import pfd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_n,
  input  logic idle,
  output logic sleep,
  output logic go_sleep
);
  pwr_state_e st, st_nx;

  always_comb begin
    st_nx = st;
    case (st)
      PW_RUN:   if (!req_n) st_nx = idle ? PW_SLEEP : PW_DRAIN;
      PW_DRAIN: if (req_n) st_nx = PW_RUN;
                else if (idle) st_nx = PW_SLEEP;
      PW_SLEEP: if (req_n) st_nx = PW_RUN;
      default:  st_nx = PW_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= PW_RUN;
    else        st <= st_nx;
  end

  assign sleep    = (st == PW_SLEEP);
  assign go_sleep = (st != PW_SLEEP) && (st_nx == PW_SLEEP);

  assert_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && req_n) |=> !sleep);
endmodule

// File: rtl/pfd_lock_gate.sv
module pfd_lock_gate #(
  parameter int CLR_DLY  = 1,
  parameter int LOCK_THR = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_div,
  input  logic vco_div,
  input  logic pol_norm,
  input  logic pd_req_n,
  output logic pump_up,
  output logic pump_dn_pull,
  output logic pump_en,
  output logic lock_ok,
  output logic ref_mon,
  output logic asleep
);
  localparam int NSIDE = 2;
  localparam int DW    = $clog2(CLR_DLY + 1);
  localparam logic [DW-1:0] LAST_V = DW'(CLR_DLY - 1);

  logic [NSIDE-1:0] pulses;
  logic [NSIDE-1:0] armed;
  logic             up_q, dn_q, both, clr, hold, go_sleep, ref_q;
  logic [DW-1:0]    dcnt;

  assign pulses = {vco_div, ref_div};
  assign up_q   = armed[0];
  assign dn_q   = armed[1];
  assign both   = up_q & dn_q;
  assign clr    = both && (dcnt == LAST_V);
  assign hold   = asleep | go_sleep;

  for (genvar i = 0; i < NSIDE; i++) begin : g_side
    pfd_side u_side (
      .clk      (clk),
      .rst_n    (rst_n),
      .pulse_in (pulses[i]),
      .hold     (hold),
      .clr      (clr),
      .armed    (armed[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     dcnt <= '0;
    else if (hold || !both || clr)  dcnt <= '0;
    else                            dcnt <= dcnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_q <= 1'b0;
    else        ref_q <= ref_div;
  end

  pfd_pwr_ctl u_pwr (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_n    (pd_req_n),
    .idle     (!up_q && !dn_q),
    .sleep    (asleep),
    .go_sleep (go_sleep)
  );

  pfd_lock_mon #(.LOCK_THR(LOCK_THR)) u_lock (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (up_q | dn_q),
    .sleep   (asleep),
    .lock_ok (lock_ok)
  );

  assign pump_up      = pol_norm ? up_q : dn_q;
  assign pump_dn_pull = pol_norm ? dn_q : up_q;
  assign pump_en      = up_q | dn_q;
  assign ref_mon      = ref_q;

  assert_joint_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!up_q && !dn_q));

  assert_defer_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep) |-> $past(!up_q && !dn_q));

  assert_sleep_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> (!pump_up && !pump_dn_pull && !pump_en && !lock_ok));
endmodule

// File: tb/tb_pfd_lock_gate.sv
`timescale 1ns/1ps
module tb_pfd_lock_gate;
  localparam int D   = 2;
  localparam int THR = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ref_div = 1'b0, vco_div = 1'b0, pol_norm = 1'b1, pd_req_n = 1'b1;
  logic pump_up, pump_dn_pull, pump_en, lock_ok, ref_mon, asleep;

  always #10 clk = ~clk;

  pfd_lock_gate #(.CLR_DLY(D), .LOCK_THR(THR)) dut (
    .clk(clk), .rst_n(rst_n), .ref_div(ref_div), .vco_div(vco_div),
    .pol_norm(pol_norm), .pd_req_n(pd_req_n), .pump_up(pump_up),
    .pump_dn_pull(pump_dn_pull), .pump_en(pump_en), .lock_ok(lock_ok),
    .ref_mon(ref_mon), .asleep(asleep)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(string tag, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  // behavioural reference model
  int m_up, m_dn, m_both, m_wid, m_st, m_pr, m_pv;
  always @(posedge clk) begin : mdl
    int idle, go, hold, clr, re, ve, nup, ndn;
    if (!rst_n) begin
      m_up = 0; m_dn = 0; m_both = 0; m_wid = 0; m_st = 0; m_pr = 0; m_pv = 0;
    end else begin
      idle = (m_up == 0 && m_dn == 0);
      go   = (m_st != 2 && !pd_req_n && idle);
      hold = (m_st == 2) || go;
      clr  = (m_up && m_dn && m_both == D - 1);
      re   = (ref_div && !m_pr);
      ve   = (vco_div && !m_pv);
      nup  = (hold || clr) ? 0 : (m_up || re);
      ndn  = (hold || clr) ? 0 : (m_dn || ve);
      m_both = (hold || !(m_up && m_dn) || clr) ? 0 : m_both + 1;
      if (!(m_up || m_dn)) m_wid = 0;
      else if (m_wid < THR) m_wid = m_wid + 1;
      if (m_st == 2) m_st = pd_req_n ? 0 : 2;
      else if (!pd_req_n) m_st = idle ? 2 : 1;
      else m_st = 0;
      m_up = nup; m_dn = ndn; m_pr = ref_div; m_pv = vco_div;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R5 pump_up",      pump_up,      pol_norm ? m_up[0] : m_dn[0]);
      chk("R5 pump_dn_pull", pump_dn_pull, pol_norm ? m_dn[0] : m_up[0]);
      chk("R6 pump_en",      pump_en,      (m_up || m_dn));
      chk("R7 lock_ok",      lock_ok,      (m_st != 2) && !((m_up || m_dn) && m_wid >= THR));
      chk("R10 ref_mon",     ref_mon,      m_pr[0]);
      chk("R8 asleep",       asleep,       (m_st == 2));
    end
  end

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 up", pump_up, 0); chk("R1 dn", pump_dn_pull, 0);
    chk("R1 en", pump_en, 0); chk("R1 lock", lock_ok, 1); chk("R1 asleep", asleep, 0);

    // R2 / R7: reference leads
    step(); ref_div = 1;
    @(negedge clk); chk("R2 up set", pump_up, 1); chk("R2 dn idle", pump_dn_pull, 0);
    chk("R6 en", pump_en, 1);
    repeat (4) @(negedge clk);
    chk("R7 lock lost", lock_ok, 0); chk("R2 up held", pump_up, 1);
    // R3 / R4
    step(); vco_div = 1;
    @(negedge clk); chk("R3 dn set", pump_dn_pull, 1); chk("R4 up kept", pump_up, 1);
    @(negedge clk); chk("R4 both held", pump_dn_pull & pump_up, 1);
    @(negedge clk); chk("R4 up clr", pump_up, 0); chk("R4 dn clr", pump_dn_pull, 0);
    chk("R7 lock back", lock_ok, 1);
    step(); ref_div = 0; vco_div = 0;
    step();

    // R11: edge during clear cycle
    step(); ref_div = 1; vco_div = 1;
    step(); ref_div = 0;
    step(); ref_div = 1;
    @(negedge clk); chk("R11 dropped", pump_up, 0);
    repeat (2) @(negedge clk);
    chk("R11 stays", pump_up, 0); chk("R11 en", pump_en, 0);
    step(); ref_div = 0; vco_div = 0;

    // R5: swapped polarity
    step(); pol_norm = 0; ref_div = 1;
    @(negedge clk); chk("R5 swap up", pump_up, 0); chk("R5 swap dn", pump_dn_pull, 1);
    step(); vco_div = 1;
    repeat (4) step();
    ref_div = 0; vco_div = 0; pol_norm = 1;
    step();

    // R8: deferred power-down
    step(); ref_div = 1;
    step(); pd_req_n = 0;
    repeat (3) @(negedge clk);
    chk("R8 deferred", asleep, 0); chk("R8 still pumping", pump_up, 1);
    step(); vco_div = 1;
    repeat (3) @(negedge clk);
    chk("R8 not yet", asleep, 0);
    @(negedge clk); chk("R8 entered", asleep, 1);

    // R9: asleep ignores edges, then wakes
    step(); ref_div = 0; vco_div = 0;
    step(); ref_div = 1;
    @(negedge clk); chk("R9 up off", pump_up, 0); chk("R9 lock low", lock_ok, 0);
    chk("R9 en off", pump_en, 0);
    step(); ref_div = 0;
    step(); pd_req_n = 1;
    @(negedge clk); chk("R9 awake", asleep, 0);
    step(); ref_div = 1;
    @(negedge clk); chk("R9 resume", pump_up, 1);
    step(); vco_div = 1;
    repeat (4) step();
    ref_div = 0; vco_div = 0;

    // sliding phase offsets with polarity and power-down windows
    for (int cyc = 0; cyc < 3000; cyc++) begin
      int off;
      step();
      off = (cyc / 150) % 16;
      ref_div  = (cyc % 16) < 4;
      vco_div  = ((cyc + off) % 16) < 4;
      pol_norm = ((cyc / 500) % 2) == 0;
      pd_req_n = !(((cyc % 400) >= 300) && ((cyc % 400) < 340));
    end
    // random pulses
    for (int cyc = 0; cyc < 2000; cyc++) begin
      step();
      ref_div  = $urandom_range(0, 3) == 0;
      vco_div  = $urandom_range(0, 3) == 0;
      if ($urandom_range(0, 49) == 0) pol_norm = ~pol_norm;
      if ($urandom_range(0, 29) == 0) pd_req_n = ~pd_req_n;
    end
    step(); pd_req_n = 1;
    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule